// File: doc/BRIEF.md
# Time-Slot Switch Host Access Port

This block is the host-side access logic of a time-slot switch. A host issues single-cycle read or write requests. One address bit chooses between an 8-bit mode register and a channel offset. A channel offset reaches one 32-entry page of a 256-entry memory. Both the page and the target memory come from the mode register, so the host programs the target once and then sweeps offsets.

Three memories can be reached:

- Connection-low memory. It is 8 bits wide and stored inside the block.
- Connection-high memory. It holds 3 bits per entry and is stored inside the block.
- Data memory. It is owned by the switch datapath, so this block only presents an address and samples the returned byte.

A split mode sends every offset read to data memory and every offset write to connection-low memory. The host can then read received samples and program connections without rewriting the mode register between the two.

The switch datapath reads both connection memories through its own registered read port. It never writes them, so host writes need no arbitration.

Top module: `tsi_host_port`

## Requirements
- R1: A request sampled on a rising edge produces `ack_o` high in the following cycle only. `rdata_o` carries the read result during the acknowledge of a read and is zero at all other times.
- R2: With `addr_i[5]` = 0 the access targets memory index `{stream, addr_i[4:0]}`, where stream is mode bits 2:0. With `addr_i[5]` = 1 the access targets the mode register.
- R3: Mode register fields: bit 7 is split, bit 6 is message mode (driven on `msg_mode_o`), bit 5 has no storage and reads 0, bits 4:3 are the memory select, bits 2:0 are the stream page. It resets to 0x00.
- R4: With split = 0, the select code picks the target for both reads and writes. Code 01 reads data memory through `dm_addr_o`/`dm_rdata_i`. Code 10 reads and writes connection-low. Code 11 reads and writes connection-high. Code 00 reads return 0x00.
- R5: With split = 0, offset writes under select code 00 or 01 change neither connection memory.
- R6: With split = 1, offset reads return data memory and offset writes go to connection-low, whatever the select code. Clearing split restores select-code routing.
- R7: Connection-high keeps bits 2:0 of written data. Its reads return bits 7:3 as zero.
- R8: `sw_cml_o` and `sw_cmh_o` show the connection-memory contents at `sw_addr_i` one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request strobe |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 6 | Bit 5 selects the mode register; bits 4:0 are the channel offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid with ack_o |
| ack_o | output | 1 | Request acknowledge |
| msg_mode_o | output | 1 | Message-mode bit of the mode register |
| dm_re_o | output | 1 | Data-memory read strobe |
| dm_addr_o | output | 8 | Data-memory read index |
| dm_rdata_i | input | 8 | Data-memory read value, sampled in the strobe cycle |
| sw_addr_i | input | 8 | Switch-side connection-memory read index |
| sw_cml_o | output | 8 | Switch-side connection-low value |
| sw_cmh_o | output | 3 | Switch-side connection-high value |

## Verification
The bench fills both connection memories across all eight pages and reads every entry back through both ports, so a wrong page concatenation shows up as aliasing between streams.

It checks these corner cases:

- Writes under the data-memory and reserved codes. A design that decoded those codes loosely would corrupt connection-low, which the switch-side port would expose.
- Split mode with the select set to connection-high. A design that let the select code win would return connection-high values instead of data memory, or would write the wrong memory.
- The unused mode bit and the missing connection-high bits. A design that stored them would read back ones where zeros are required.

// File: rtl/tsi_host_pkg.sv
package tsi_host_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned STREAM_W = 3;
  localparam int unsigned CH_W     = 5;
  localparam int unsigned IDX_W    = STREAM_W + CH_W;
  localparam int unsigned ADDR_W   = CH_W + 1;
  localparam int unsigned CMH_W    = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DM   = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_CTRL,
    SRC_DM,
    SRC_CML,
    SRC_CMH
  } rd_src_e;

  typedef struct packed {
    logic                split;
    logic                msg;
    logic                spare;
    mem_sel_e            sel;
    logic [STREAM_W-1:0] stream;
  } mode_t;

  localparam logic [REG_W-1:0] SPARE_MASK = 8'h20;
endpackage

// File: rtl/tsi_mode_reg.sv
module tsi_mode_reg
  import tsi_host_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output mode_t            mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= mode_t'('0);
    else if (we_i) mode_q <= mode_t'(wdata_i & ~SPARE_MASK);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/tsi_access_decode.sv
module tsi_access_decode
  import tsi_host_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mode_t             mode_i,
  output logic              mode_we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              dm_re_o,
  output logic              cm_re_o,
  output logic              cml_we_o,
  output logic              cmh_we_o,
  output rd_src_e           rd_src_o
);
  logic     reg_hit, mem_op;
  mem_sel_e rd_sel, wr_sel;

  always_comb begin
    reg_hit   = addr_i[ADDR_W-1];
    mem_op    = req_i && !reg_hit;
    idx_o     = {mode_i.stream, addr_i[CH_W-1:0]};
    // split mode overrides the select code for both directions
    rd_sel    = mode_i.split ? SEL_DM  : mode_i.sel;
    wr_sel    = mode_i.split ? SEL_CML : mode_i.sel;
    mode_we_o = req_i && we_i && reg_hit;
    dm_re_o   = mem_op && !we_i && (rd_sel == SEL_DM);
    cm_re_o   = mem_op && !we_i;
    cml_we_o  = mem_op && we_i && (wr_sel == SEL_CML);
    cmh_we_o  = mem_op && we_i && (wr_sel == SEL_CMH);
    if (reg_hit) rd_src_o = SRC_CTRL;
    else begin
      unique case (rd_sel)
        SEL_DM:  rd_src_o = SRC_DM;
        SEL_CML: rd_src_o = SRC_CML;
        SEL_CMH: rd_src_o = SRC_CMH;
        default: rd_src_o = SRC_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/tsi_conn_ram.sv
module tsi_conn_ram #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             h_we_i,
  input  logic             h_re_i,
  input  logic [IDX_W-1:0] h_idx_i,
  input  logic [WIDTH-1:0] h_wdata_i,
  output logic [WIDTH-1:0] h_rdata_o,
  input  logic [IDX_W-1:0] s_idx_i,
  output logic [WIDTH-1:0] s_rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] h_rd_q, s_rd_q;

  always_ff @(posedge clk_i) begin
    if (h_we_i) mem_q[h_idx_i] <= h_wdata_i;
    if (h_re_i) h_rd_q <= mem_q[h_idx_i];
    s_rd_q <= mem_q[s_idx_i];
  end

  assign h_rdata_o = h_rd_q;
  assign s_rdata_o = s_rd_q;
endmodule

// File: rtl/tsi_read_mux.sv
module tsi_read_mux
  import tsi_host_pkg::*;
(
  input  rd_src_e          src_i,
  input  mode_t            mode_i,
  input  logic [REG_W-1:0] dm_i,
  input  logic [REG_W-1:0] cml_i,
  input  logic [CMH_W-1:0] cmh_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] cmh_ext;

  // connection-high has no storage above its low bits
  generate
    if (CMH_W < REG_W) begin : g_pad
      assign cmh_ext = {{(REG_W-CMH_W){1'b0}}, cmh_i};
    end else begin : g_full
      assign cmh_ext = cmh_i[REG_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_CTRL: rdata_o = REG_W'(mode_i) & ~SPARE_MASK;
      SRC_DM:   rdata_o = dm_i;
      SRC_CML:  rdata_o = cml_i;
      SRC_CMH:  rdata_o = cmh_ext;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
  import tsi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              ack_o,
  output logic              msg_mode_o,
  output logic              dm_re_o,
  output logic [IDX_W-1:0]  dm_addr_o,
  input  logic [REG_W-1:0]  dm_rdata_i,
  input  logic [IDX_W-1:0]  sw_addr_i,
  output logic [REG_W-1:0]  sw_cml_o,
  output logic [CMH_W-1:0]  sw_cmh_o
);
  mode_t            mode;
  logic             mode_we, dm_re, cm_re, cml_we, cmh_we;
  logic [IDX_W-1:0] idx;
  rd_src_e          rd_src, rd_src_q;
  logic             ack_q;
  logic [REG_W-1:0] dm_q, cml_rd;
  logic [CMH_W-1:0] cmh_rd;

  tsi_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we),
    .wdata_i (wdata_i),
    .mode_o  (mode)
  );

  tsi_access_decode u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .mode_i    (mode),
    .mode_we_o (mode_we),
    .idx_o     (idx),
    .dm_re_o   (dm_re),
    .cm_re_o   (cm_re),
    .cml_we_o  (cml_we),
    .cmh_we_o  (cmh_we),
    .rd_src_o  (rd_src)
  );

  tsi_conn_ram #(.WIDTH(REG_W), .IDX_W(IDX_W)) u_cml (
    .clk_i     (clk_i),
    .h_we_i    (cml_we),
    .h_re_i    (cm_re),
    .h_idx_i   (idx),
    .h_wdata_i (wdata_i),
    .h_rdata_o (cml_rd),
    .s_idx_i   (sw_addr_i),
    .s_rdata_o (sw_cml_o)
  );

  tsi_conn_ram #(.WIDTH(CMH_W), .IDX_W(IDX_W)) u_cmh (
    .clk_i     (clk_i),
    .h_we_i    (cmh_we),
    .h_re_i    (cm_re),
    .h_idx_i   (idx),
    .h_wdata_i (wdata_i[CMH_W-1:0]),
    .h_rdata_o (cmh_rd),
    .s_idx_i   (sw_addr_i),
    .s_rdata_o (sw_cmh_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      rd_src_q <= SRC_ZERO;
      dm_q     <= '0;
    end else begin
      ack_q    <= req_i;
      rd_src_q <= (req_i && !we_i) ? rd_src : SRC_ZERO;
      if (dm_re) dm_q <= dm_rdata_i;
    end
  end

  tsi_read_mux u_mux (
    .src_i   (rd_src_q),
    .mode_i  (mode),
    .dm_i    (dm_q),
    .cml_i   (cml_rd),
    .cmh_i   (cmh_rd),
    .rdata_o (rdata_o)
  );

  assign ack_o      = ack_q;
  assign msg_mode_o = mode.msg;
  assign dm_re_o    = dm_re;
  assign dm_addr_o  = idx;
endmodule

// File: rtl/tsi_host_port_chk.sv
module tsi_host_port_chk
  import tsi_host_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              ack_o,
  input logic              dm_re_o,
  input logic [REG_W-1:0]  dm_rdata_i,
  input mode_t             mode,
  input logic              cml_we,
  input logic              cmh_we
);
  a_r1_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  a_r1_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  a_r1_rdata_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);
  a_r3_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1]) |=> REG_W'(mode) == ($past(wdata_i) & ~SPARE_MASK));
  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i[ADDR_W-1]) |=> $stable(mode));
  a_r3_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1]) |=> rdata_o[5] == 1'b0);
  a_r5_no_write_dm_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !mode.split && (mode.sel == SEL_DM || mode.sel == SEL_NONE))
      |-> !cml_we && !cmh_we);
  a_r6_split_read_dm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_i[ADDR_W-1] && mode.split) |=> rdata_o == $past(dm_rdata_i));
  a_r6_split_write_cml: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_i[ADDR_W-1] && mode.split) |-> cml_we && !cmh_we && !dm_re_o);
  a_r7_cmh_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !addr_i[ADDR_W-1] && !mode.split && mode.sel == SEL_CMH)
      |=> rdata_o[REG_W-1:CMH_W] == '0);
endmodule

bind tsi_host_port tsi_host_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ack_o      (ack_o),
  .dm_re_o    (dm_re_o),
  .dm_rdata_i (dm_rdata_i),
  .mode       (mode),
  .cml_we     (cml_we),
  .cmh_we     (cmh_we)
);

// File: tb/tb_tsi_host_port.sv
module tb_tsi_host_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, dm_addr, dm_rdata, sw_cml;
  logic [7:0] sw_addr = '0;
  logic [2:0] sw_cmh;
  logic       ack, msg_mode, dm_re;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] dm_val(input logic [7:0] a);
    return 8'((a * 3) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] cml_val(input int s, input int c);
    return 8'(s * 37 + c * 11 + 5);
  endfunction
  function automatic logic [2:0] cmh_val(input int s, input int c);
    return 3'(s + c);
  endfunction

  assign dm_rdata = dm_val(dm_addr);

  tsi_host_port dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .msg_mode_o(msg_mode),
    .dm_re_o(dm_re), .dm_addr_o(dm_addr), .dm_rdata_i(dm_rdata),
    .sw_addr_i(sw_addr), .sw_cml_o(sw_cml), .sw_cmh_o(sw_cmh)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // drive at negedge, response registered at next posedge, sampled next negedge
  task automatic host(input bit w, input logic [5:0] a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk(ack === 1'b1, "R1 ack", int'(ack), 1);
    r = rdata;
    if (w) chk(rdata === 8'h00, "R1 write rdata", int'(rdata), 0);
  endtask

  task automatic set_mode(input logic [7:0] m);
    logic [7:0] r;
    host(1'b1, 6'h20, m, r);
  endtask

  task automatic sw_read(input logic [7:0] i, output logic [7:0] l, output logic [2:0] h);
    @(negedge clk);
    sw_addr = i;
    @(negedge clk);
    l = sw_cml; h = sw_cmh;
  endtask

  initial begin
    logic [7:0] r, l;
    logic [2:0] h;
    repeat (3) @(negedge clk);
    chk(ack === 1'b0, "R1 reset ack", int'(ack), 0);
    chk(rdata === 8'h00, "R1 reset rdata", int'(rdata), 0);
    chk(msg_mode === 1'b0, "R3 reset msg", int'(msg_mode), 0);
    rst_n = 1'b1;
    host(1'b0, 6'h20, 8'h00, r);
    chk(r === 8'h00, "R3 reset mode", int'(r), 0);
    @(negedge clk);
    chk(ack === 1'b0, "R1 single ack", int'(ack), 0);
    chk(rdata === 8'h00, "R1 idle rdata", int'(rdata), 0);

    // R3 fields, spare bit 5 reads zero
    set_mode(8'hFF);
    host(1'b0, 6'h20, 8'h00, r);
    chk(r === 8'hDF, "R3 mode readback", int'(r), 'hDF);
    chk(msg_mode === 1'b1, "R3 msg bit", int'(msg_mode), 1);
    set_mode(8'h40);
    host(1'b0, 6'h20, 8'h00, r);
    chk(r === 8'h40, "R3 mode readback 40", int'(r), 'h40);

    // R2 R4 fill both connection memories on every page
    for (int s = 0; s < 8; s++) begin
      set_mode(8'h10 | 8'(s));
      for (int c = 0; c < 32; c++) host(1'b1, 6'(c), cml_val(s, c), r);
      set_mode(8'h18 | 8'(s));
      for (int c = 0; c < 32; c++) host(1'b1, 6'(c), 8'hF8 | 8'(cmh_val(s, c)), r);
    end
    // R8 R2 switch-side sweep
    for (int i = 0; i < 256; i++) begin
      sw_read(8'(i), l, h);
      chk(l === cml_val(i / 32, i % 32), "R8 cml", int'(l), int'(cml_val(i / 32, i % 32)));
      chk(h === cmh_val(i / 32, i % 32), "R8 cmh", int'(h), int'(cmh_val(i / 32, i % 32)));
    end
    // R4 R7 host readback, R4 data memory page reads
    for (int s = 0; s < 8; s++) begin
      set_mode(8'h10 | 8'(s));
      for (int c = 0; c < 32; c++) begin
        host(1'b0, 6'(c), 8'h00, r);
        chk(r === cml_val(s, c), "R4 cml read", int'(r), int'(cml_val(s, c)));
      end
      set_mode(8'h18 | 8'(s));
      for (int c = 0; c < 32; c++) begin
        host(1'b0, 6'(c), 8'h00, r);
        chk(r === {5'b0, cmh_val(s, c)}, "R7 cmh read", int'(r), int'(cmh_val(s, c)));
      end
      set_mode(8'h08 | 8'(s));
      for (int c = 0; c < 32; c++) begin
        host(1'b0, 6'(c), 8'h00, r);
        chk(r === dm_val(8'(s * 32 + c)), "R4 dm read", int'(r), int'(dm_val(8'(s * 32 + c))));
      end
    end
    set_mode(8'h03);
    host(1'b0, 6'h07, 8'h00, r);
    chk(r === 8'h00, "R4 reserved read", int'(r), 0);

    // R5 writes under codes 00 and 01 are dropped
    set_mode(8'h02);
    for (int c = 0; c < 32; c++) host(1'b1, 6'(c), 8'h00, r);
    set_mode(8'h0A);
    for (int c = 0; c < 32; c++) host(1'b1, 6'(c), 8'h00, r);
    for (int c = 0; c < 32; c++) begin
      sw_read(8'(64 + c), l, h);
      chk(l === cml_val(2, c) && h === cmh_val(2, c), "R5 ignored write",
          int'({h, l}), int'({cmh_val(2, c), cml_val(2, c)}));
    end

    // R6 split with select on connection-high
    set_mode(8'h98 | 8'h05);
    for (int c = 0; c < 32; c++) begin
      host(1'b0, 6'(c), 8'h00, r);
      chk(r === dm_val(8'(160 + c)), "R6 split read", int'(r), int'(dm_val(8'(160 + c))));
      host(1'b1, 6'(c), 8'(~cml_val(5, c)), r);
    end
    for (int c = 0; c < 32; c++) begin
      sw_read(8'(160 + c), l, h);
      chk(l === 8'(~cml_val(5, c)), "R6 split cml write", int'(l), int'(8'(~cml_val(5, c))));
      chk(h === cmh_val(5, c), "R6 cmh untouched", int'(h), int'(cmh_val(5, c)));
    end
    set_mode(8'h18 | 8'h05);
    host(1'b0, 6'h04, 8'h00, r);
    chk(r === {5'b0, cmh_val(5, 4)}, "R6 split cleared", int'(r), int'(cmh_val(5, 4)));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule